// File: doc/BRIEF.md
# Sector Page-Load Write Controller with Command Unlock

This block is the write path of a parallel flash array built from 256-byte sectors. It watches the active-low chip-enable, write-enable and output-enable pins and sorts each bus cycle into a read or a write strobe. Reads behave like an asynchronous static RAM and return array contents, with sector boundaries playing no part. Writes are refused unless a fixed three-cycle command opens a load window. Inside that window, byte loads fill a one-sector staging buffer.

The load window closes when no new strobe begins within a set number of clock cycles after the previous one ended. The block then enters a modelled internal erase-and-program period. At the end of that period the whole target sector is replaced at once. Bytes that were loaded take their new values and every other byte of the sector becomes 0xFF, so no separate erase command exists. While the period runs, reads return a polling status byte instead of array data.

A write that does not follow the command sequence stores nothing. It still starts the same busy period, so polling status appears on reads until that period ends. Every program operation needs a fresh command.

Top module: `fx_sector_writer`

## Requirements
- R1: With chip-enable and output-enable low, write-enable high and the block not busy, `dq` shows the array byte at `addr` in the same cycle and `dq_oe` is 1. When no read is in progress, `dq_oe` is 0 and `dq` is 0.
- R2: The byte offset within a sector is formed as {top OFS_HI_W address bits, low OFS_LO_W address bits}, with the top bits as the high part of the offset. The sector number is the SEC_W address bits just above the low offset bits. The sector that gets programmed is the one addressed by the first byte loaded after the command, and later loads contribute only their offset.
- R3: A load window opens only after three consecutive write cycles: 0xAA to unlock address A, then 0x55 to unlock address B, then 0xA0 to unlock address A. Address A is the low bits of 0x5555 and address B is the low bits of 0x2AAA, truncated to the address width.
- R4: A write cycle in the idle state that does not match the next expected command cycle resets the sequencer. It stores no data and starts the busy period.
- R5: A write strobe is chip-enable and write-enable both low with output-enable high. The address is taken when the later of the two enables falls. The data is the value present in the last cycle before the first of the two enables rises.
- R6: Once the window is open, if the write strobe stays inactive for WIN_CYC consecutive cycles, the window closes and the busy period begins.
- R7: At the end of a program period, every byte of the target sector that was loaded takes its loaded value, every byte that was not loaded becomes 0xFF, and all other sectors keep their contents.
- R8: The busy period lasts BUSY_CYC cycles. While busy, a read returns bit 7 as the inverse of bit 7 of the last byte written, bit 6 as a toggle that flips at the end of every read, and bits 5..0 as 0. Write cycles during the busy period have no effect.
- R9: After a program completes, the block is idle again, and a write without a new command is handled as in R4.
- R10: If the window closes with no byte loaded, the block returns to idle without a busy period and the array is unchanged.
- R11: After reset, the block is idle and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | OFS_LO_W+OFS_HI_W+SEC_W | Byte address |
| din | input | 8 | Write data |
| dq | output | 8 | Read data or polling status |
| dq_oe | output | 1 | High while a read drives `dq` |

## Verification
The bench builds the block with OFS_LO_W=2, OFS_HI_W=1 and SEC_W=2, which gives four sectors of eight bytes and a five-bit address. It also uses WIN_CYC=20 and BUSY_CYC=40. At this size, every array byte can be read back after each program operation. Every sector can be programmed with its own load mask, and the split offset field, the address captured at the later enable fall, the window timeout and the polling status can all be reached within a few thousand cycles.

// File: rtl/fx_pkg.sv
package fx_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_LOAD = 2'd1, ST_BUSY = 2'd2} fx_state_t;

  localparam logic [7:0]  CMD_D0 = 8'hAA;
  localparam logic [7:0]  CMD_D1 = 8'h55;
  localparam logic [7:0]  CMD_D2 = 8'hA0;
  localparam logic [14:0] CMD_AA = 15'h5555;
  localparam logic [14:0] CMD_AB = 15'h2AAA;

  // sector number: the sec_w bits just above the low offset field
  function automatic int unsigned sec_of(input logic [31:0] a, input int lo_w, input int sec_w);
    return (a >> lo_w) & ((32'd1 << sec_w) - 32'd1);
  endfunction

  // offset: top hi_w address bits on top, low lo_w address bits below
  function automatic int unsigned ofs_of(input logic [31:0] a, input int lo_w,
                                         input int hi_w, input int aw);
    logic [31:0] hi, lo;
    hi = a >> (aw - hi_w);
    lo = a & ((32'd1 << lo_w) - 32'd1);
    return (hi << lo_w) | lo;
  endfunction

  function automatic logic [7:0] poll_byte(input logic [7:0] last, input logic tog);
    return {~last[7], tog, 6'b0};
  endfunction
endpackage

// File: rtl/fx_bus_edge.sv
module fx_bus_edge #(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic          wr_act,
  output logic          rd_act,
  output logic          wr_start,
  output logic          wr_end,
  output logic          rd_end,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data
);
  logic wr_q, rd_q;

  assign wr_act   = !ce_n && !we_n && oe_n;
  assign rd_act   = !ce_n && !oe_n && we_n;
  assign wr_start = wr_act && !wr_q;   // later of the two enables fell
  assign wr_end   = !wr_act && wr_q;   // first of the two enables rose
  assign rd_end   = !rd_act && rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      if (wr_start) wr_addr <= addr;
      if (wr_act)   wr_data <= din;
    end
  end

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && wr_act) |=> $stable(wr_addr));
  p_end_after_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_end |-> $past(wr_act));
endmodule

// File: rtl/fx_unlock.sv
module fx_unlock
  import fx_pkg::*;
#(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          ev,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    data,
  output logic          ok,
  output logic          bad
);
  localparam int UW = (AW < 15) ? AW : 15;

  logic [1:0] step;
  logic       match;

  always_comb begin
    unique case (step)
      2'd0:    match = (data == CMD_D0) && (addr[UW-1:0] == CMD_AA[UW-1:0]);
      2'd1:    match = (data == CMD_D1) && (addr[UW-1:0] == CMD_AB[UW-1:0]);
      2'd2:    match = (data == CMD_D2) && (addr[UW-1:0] == CMD_AA[UW-1:0]);
      default: match = 1'b0;
    endcase
  end

  assign ok  = en && ev && match && (step == 2'd2);
  assign bad = en && ev && !match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 step <= 2'd0;
    else if (!en)               step <= 2'd0;
    else if (ev)                step <= (match && step != 2'd2) ? step + 2'd1 : 2'd0;
  end

  p_step_range_r3: assert property (@(posedge clk) disable iff (!rst_n) step != 2'd3);
  p_bad_clears_r4: assert property (@(posedge clk) disable iff (!rst_n) bad |=> step == 2'd0);
endmodule

// File: rtl/fx_timers.sv
module fx_timers #(
  parameter int WIN_CYC  = 37500,
  parameter int BUSY_CYC = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic loading,
  input  logic busy,
  input  logic wr_act,
  output logic win_exp,
  output logic busy_done
);
  localparam int WW = $clog2(WIN_CYC + 1);
  localparam int BW = $clog2(BUSY_CYC + 1);

  logic [WW-1:0] win_cnt;
  logic [BW-1:0] busy_cnt;

  assign win_exp   = loading && !wr_act && (win_cnt == WW'(WIN_CYC - 1));
  assign busy_done = busy && (busy_cnt == BW'(BUSY_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt  <= '0;
      busy_cnt <= '0;
    end else begin
      win_cnt  <= (!loading || wr_act || win_exp) ? '0 : win_cnt + 1'b1;
      busy_cnt <= (!busy || busy_done) ? '0 : busy_cnt + 1'b1;
    end
  end

  p_win_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    win_cnt < WW'(WIN_CYC));
  p_busy_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt < BW'(BUSY_CYC));
endmodule

// File: rtl/fx_sector_writer.sv
module fx_sector_writer
  import fx_pkg::*;
#(
  parameter int OFS_LO_W = 4,
  parameter int OFS_HI_W = 4,
  parameter int SEC_W    = 2,
  parameter int WIN_CYC  = 37500,
  parameter int BUSY_CYC = 250000
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                ce_n,
  input  logic                                we_n,
  input  logic                                oe_n,
  input  logic [OFS_LO_W+OFS_HI_W+SEC_W-1:0]  addr,
  input  logic [7:0]                          din,
  output logic [7:0]                          dq,
  output logic                                dq_oe
);
  localparam int OFS_W  = OFS_LO_W + OFS_HI_W;
  localparam int ADDR_W = OFS_W + SEC_W;
  localparam int BYTES  = 1 << OFS_W;
  localparam int NWORDS = 1 << ADDR_W;

  logic              wr_act, rd_act, wr_start, wr_end, rd_end;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  fx_state_t         state;
  logic              cmd_ok, cmd_bad, win_exp, busy_done;

  fx_bus_edge #(.AW(ADDR_W)) u_bus (
    .clk, .rst_n, .ce_n, .we_n, .oe_n, .addr, .din,
    .wr_act, .rd_act, .wr_start, .wr_end, .rd_end, .wr_addr, .wr_data
  );

  fx_unlock #(.AW(ADDR_W)) u_unl (
    .clk, .rst_n, .en(state == ST_IDLE), .ev(wr_end),
    .addr(wr_addr), .data(wr_data), .ok(cmd_ok), .bad(cmd_bad)
  );

  fx_timers #(.WIN_CYC(WIN_CYC), .BUSY_CYC(BUSY_CYC)) u_tmr (
    .clk, .rst_n, .loading(state == ST_LOAD), .busy(state == ST_BUSY),
    .wr_act, .win_exp, .busy_done
  );

  logic [7:0]       pbuf [BYTES];
  logic [BYTES-1:0] vld;
  logic [SEC_W-1:0] sec_q;
  logic             any_ld, pend, tog;
  logic [7:0]       last_q;
  logic [7:0]       mem [NWORDS];

  logic [OFS_W-1:0]  w_ofs, r_ofs;
  logic [SEC_W-1:0]  w_sec, r_sec;
  logic              buf_we, mem_we;

  assign w_ofs  = OFS_W'(ofs_of(32'(wr_addr), OFS_LO_W, OFS_HI_W, ADDR_W));
  assign w_sec  = SEC_W'(sec_of(32'(wr_addr), OFS_LO_W, SEC_W));
  assign r_ofs  = OFS_W'(ofs_of(32'(addr), OFS_LO_W, OFS_HI_W, ADDR_W));
  assign r_sec  = SEC_W'(sec_of(32'(addr), OFS_LO_W, SEC_W));
  assign buf_we = (state == ST_LOAD) && wr_end;
  assign mem_we = busy_done && pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      vld    <= '0;
      sec_q  <= '0;
      any_ld <= 1'b0;
      pend   <= 1'b0;
      tog    <= 1'b0;
      last_q <= 8'hFF;
    end else begin
      if (state == ST_BUSY && rd_end) tog <= ~tog;
      unique case (state)
        ST_IDLE: begin
          if (cmd_ok) begin
            state  <= ST_LOAD;
            vld    <= '0;
            any_ld <= 1'b0;
          end else if (cmd_bad) begin
            state  <= ST_BUSY;
            pend   <= 1'b0;
            last_q <= wr_data;
          end
        end
        ST_LOAD: begin
          if (buf_we) begin
            vld[w_ofs] <= 1'b1;
            last_q     <= wr_data;
            any_ld     <= 1'b1;
            if (!any_ld) sec_q <= w_sec;
          end else if (win_exp) begin
            state <= any_ld ? ST_BUSY : ST_IDLE;
            pend  <= any_ld;
          end
        end
        ST_BUSY: if (busy_done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[w_ofs] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) mem[i] <= 8'hFF;
    end else if (mem_we) begin
      for (int i = 0; i < BYTES; i++)
        mem[{sec_q, OFS_W'(i)}] <= vld[i] ? pbuf[i] : 8'hFF;
    end
  end

  always_comb begin
    dq = 8'h00;
    if (rd_act) dq = (state == ST_BUSY) ? poll_byte(last_q, tog) : mem[{r_sec, r_ofs}];
  end
  assign dq_oe = rd_act;

  p_quiet_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> dq == 8'h00);
  p_bad_to_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_bad |=> state == ST_BUSY);
  p_prog_from_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> state == ST_BUSY);
  p_poll_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY && rd_end) |=> tog != $past(tog));
  p_busy_no_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY && wr_end) |=> $stable(vld));
  p_empty_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (win_exp && !any_ld) |=> state == ST_IDLE);
endmodule

// File: tb/tb_fx_sector_writer.sv
module tb_fx_sector_writer;
  localparam int LO = 2, HI = 1, SW = 2, WIN = 20, BSY = 40;
  localparam int NW = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [4:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dq;
  logic       dq_oe;

  always #2 clk = ~clk;

  fx_sector_writer #(.OFS_LO_W(LO), .OFS_HI_W(HI), .SEC_W(SW),
                     .WIN_CYC(WIN), .BUSY_CYC(BSY)) dut (
    .clk, .rst_n, .ce_n, .we_n, .oe_n, .addr, .din, .dq, .dq_oe
  );

  int total = 0, fails = 0;
  logic [7:0] model [NW];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // address bit 4 = offset bit 2, bits 3:2 = sector, bits 1:0 = offset bits 1:0
  function automatic logic [4:0] mk(input int s, input int o);
    return {o[2], s[1:0], o[1:0]};
  endfunction

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; ce_n = 0; we_n = 0;
    @(negedge clk);
    @(negedge clk); ce_n = 1; we_n = 1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk); addr = a; ce_n = 0; oe_n = 0;
    #1; d = dq; oe = dq_oe;
    @(negedge clk); ce_n = 1; oe_n = 1;
    @(negedge clk);
  endtask

  task automatic unlock();
    wr(5'h15, 8'hAA); wr(5'h0A, 8'h55); wr(5'h15, 8'hA0);
  endtask

  task automatic check_all(input string tag);
    logic [7:0] d; logic oe;
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 8; o++) begin
        rd(mk(s, o), d, oe);
        chk(d == model[s*8+o] && oe, tag, d, model[s*8+o]);
      end
  endtask

  task automatic prog(input int s, input logic [7:0] mask, input int seed);
    unlock();
    for (int o = 0; o < 8; o++)
      if (mask[o]) wr(mk(s, o), 8'(s*37 + o*11 + seed));
    for (int o = 0; o < 8; o++)
      model[s*8+o] = mask[o] ? 8'(s*37 + o*11 + seed) : 8'hFF;
    waitc(WIN + BSY + 10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] d, d2; logic oe;
    for (int i = 0; i < NW; i++) model[i] = 8'hFF;
    waitc(3); rst_n = 1; waitc(2);

    // R1 R11: idle bus and erased array after reset
    chk(dq_oe == 0 && dq == 0, "R1 idle bus", {dq_oe, dq}, 0);
    check_all("R11 reset array");

    // R3 R7 R8: full sector program with polling during busy
    unlock();
    for (int o = 0; o < 8; o++) wr(mk(1, o), 8'(8'h80 | o));
    for (int o = 0; o < 8; o++) model[8+o] = 8'(8'h80 | o);
    waitc(WIN + 4);
    rd(mk(1, 0), d, oe);
    chk(d[7] == 1'b0 && d[5:0] == 0 && oe, "R8 poll bits", d, 0);
    rd(mk(1, 0), d2, oe);
    chk(d2[6] != d[6], "R8 toggle", d2[6], ~d[6]);
    wr(mk(1, 0), 8'h00);  // R8: write during busy ignored
    waitc(WIN + BSY + 10);
    check_all("R7 full sector");

    // R7 R2: every sector with its own partial mask
    for (int s = 0; s < 4; s++) begin
      prog(s, 8'h55 << (s & 1) | 8'(s << 4), s * 3);
      check_all("R7 partial mask");
    end

    // R2: sector fixed by first load
    unlock();
    wr(mk(2, 0), 8'h10); wr(mk(1, 5), 8'h25);
    for (int o = 0; o < 8; o++) model[16+o] = 8'hFF;
    model[16] = 8'h10; model[16+5] = 8'h25;
    waitc(WIN + BSY + 10);
    check_all("R2 target sector");

    // R5: address at later fall, data at first rise
    unlock();
    @(negedge clk); addr = mk(3, 0); din = 8'h11; ce_n = 0; we_n = 0;
    @(negedge clk); addr = mk(3, 1); din = 8'h22;
    @(negedge clk); ce_n = 1; we_n = 1; din = 8'h99;
    @(negedge clk);
    @(negedge clk); addr = mk(3, 2); din = 8'h33; we_n = 0;
    @(negedge clk); addr = mk(3, 4); din = 8'h44; ce_n = 0;
    @(negedge clk);
    @(negedge clk); ce_n = 1; din = 8'h77;
    @(negedge clk); we_n = 1;
    @(negedge clk);
    for (int o = 0; o < 8; o++) model[24+o] = 8'hFF;
    model[24] = 8'h22; model[28] = 8'h44;
    waitc(WIN + BSY + 10);
    check_all("R5 capture edges");

    // R6 R8: gap inside window keeps loading, gap past window closes it
    unlock();
    wr(mk(0, 0), 8'hA1);
    waitc(WIN - 6);
    wr(mk(0, 7), 8'hB7);
    waitc(WIN + 3);
    rd(mk(0, 7), d, oe);
    chk(d == 8'h00, "R6 window closed busy", d, 8'h00);
    wr(mk(0, 3), 8'hC3);
    for (int o = 0; o < 8; o++) model[o] = 8'hFF;
    model[0] = 8'hA1; model[7] = 8'hB7;
    waitc(WIN + BSY + 10);
    check_all("R6 window");

    // R4 R9: write without command after a program
    wr(mk(1, 2), 8'h12);
    rd(mk(1, 2), d, oe);
    chk(d[7] == 1'b1 && d[5:0] == 0, "R9 plain write polls", d, 8'h80);
    waitc(BSY + 10);
    check_all("R4 plain write no store");

    // R4: broken command sequence
    wr(5'h15, 8'hAA); wr(5'h0B, 8'h55);
    rd(mk(2, 2), d, oe);
    chk(d[7] == 1'b1 && d[5:0] == 0, "R4 broken command polls", d, 8'h80);
    waitc(BSY + 10);
    wr(5'h15, 8'hA0);
    waitc(BSY + 10);
    check_all("R4 broken command no store");

    // R10: command then no load
    unlock();
    waitc(WIN + 5);
    rd(mk(3, 0), d, oe);
    chk(d == model[24], "R10 idle after empty window", d, model[24]);
    check_all("R10 array unchanged");

    // R3: command still works afterwards
    prog(2, 8'hFF, 7);
    check_all("R3 command program");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule